// File: doc/BRIEF.md
# Adaptive Threshold Data Slicer

This block turns a stream of filtered frequency-discriminator samples into hard data bits. It takes one signed word per clock and keeps two level trackers. One follows the most positive excursion of the signal and the other follows the most negative. Each tracker snaps out at once to any sample that lies beyond it. At each bit time it relaxes back toward the midpoint of the two levels. Because the midpoint of the two levels sits on the signal's DC level, the slicing point follows both offset and amplitude without any external trimming.

A mid-bit strobe from an external clock recovery loop marks the instant at which a bit is decided. At that instant the current sample is compared with the threshold. The threshold is the level midpoint, shifted up or down by a fraction of the peak-to-peak span. This shift follows the previously decided bit and cancels intersymbol interference from the bit before. The fraction is set by a Gaussian-filter bandwidth selection. An acquire input makes the trackers relax quickly while a burst is being picked up, and slowly once the link has settled.

The decided bit is registered. It is held steady between strobes, so a downstream circuit can capture it on the rising edge of the recovered clock.

Top module: `isi_slicer`

## Requirements
- R1: A synchronous active-high reset sets both level trackers and the previous-bit register to 0, and drives `bit_o` and `bit_vld_o` low from the first clock edge after the reset.
- R2: When a sample is greater than the positive level, that level takes the sample's value on the same clock edge. This happens whether or not a strobe is present.
- R3: When a sample is less than the negative level, that level takes the sample's value on the same clock edge. This happens whether or not a strobe is present.
- R4: Let mid be floor((pos+neg)/2), computed from the levels held before the edge. On a strobe edge where a level does not jump, the positive level becomes pos - floor((pos-mid)/2^d) and the negative level becomes neg + floor((mid-neg)/2^d). On edges with no strobe and no jump, both levels keep their values.
- R5: The threshold is mid + k when the previous bit is 1, and mid - k when it is 0. Here k = floor((pos-neg)/2^s), with s = 2 when `bt_sel_i` is 0 (narrow filter) and s = 3 when `bt_sel_i` is 1 (wide filter).
- R6: On a strobe, the decided bit is 1 only if the sample is strictly greater than the threshold. A sample equal to or below the threshold gives 0. The threshold is computed from the levels held before that edge, even when the same sample also moves a level.
- R7: `bit_o` and `bit_vld_o` change on the clock edge that samples the strobe. `bit_vld_o` is high for exactly one cycle per strobe cycle, and `bit_o` keeps its value on every edge without a strobe.
- R8: The previous-bit register used in R5 is the last decided bit.
- R9: `acquire_i`, sampled at the strobe edge, selects the relaxation divisor: d = 4 when it is 1 and d = 8 when it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 8 | Filtered discriminator sample, two's complement |
| mid_stb_i | input | 1 | Mid-bit strobe: decide a bit on this sample |
| acquire_i | input | 1 | 1 = fast level relaxation, 0 = slow |
| bt_sel_i | input | 1 | 0 = narrow filter (s=2), 1 = wide filter (s=3) |
| bit_o | output | 1 | Decided data bit, held between strobes |
| bit_vld_o | output | 1 | One-cycle pulse marking a new decision |

## Verification
A sample that lies outside a level can arrive in the same cycle as a strobe. In that cycle a level jump coincides with a decision and with the scheduled relaxation. The bench provokes this on purpose: right after reset it strobes a sample just above zero, and later it strobes samples that overshoot the stored peaks. It judges the result in two ways. First, the bit from that cycle must follow the threshold held before the edge. Second, the decisions on later strobes must match a model in which the jump replaced the relaxation for that cycle.

// File: rtl/slicer_pkg.sv
package slicer_pkg;
  // Relaxation divisors (log2) for the two tracking speeds.
  localparam int unsigned RELAX_FAST = 4;
  localparam int unsigned RELAX_SLOW = 8;
  // Span fractions (log2) for the two filter bandwidth settings.
  localparam int unsigned SPAN_NARROW = 2;
  localparam int unsigned SPAN_WIDE   = 3;

  typedef enum logic {
    TRACK_SLOW = 1'b0,
    TRACK_FAST = 1'b1
  } track_e;

  typedef enum logic {
    FILT_NARROW = 1'b0,
    FILT_WIDE   = 1'b1
  } filt_e;
endpackage

// File: rtl/slicer_level.sv
module slicer_level #(
  parameter int W         = 8,
  parameter bit IS_POS    = 1'b1,
  parameter int SH_FAST   = 4,
  parameter int SH_SLOW   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] din,
  input  logic signed [W:0]   mid,
  input  logic                stb,
  input  logic                fast,
  output logic signed [W-1:0] level
);
  logic                jump;
  logic signed [W:0]   gap;
  logic signed [W:0]   step;
  logic signed [W:0]   nxt;
  logic signed [W:0]   level_x;

  assign level_x = {level[W-1], level};
  assign step    = fast ? (gap >>> SH_FAST) : (gap >>> SH_SLOW);

  generate
    if (IS_POS) begin : g_pos
      always_comb begin
        jump = din > level;
        gap  = level_x - mid;
        nxt  = level_x - step;
      end
      // R2: an excursion above the level is captured at once
      a_r2_pos_jump: assert property (@(posedge clk) disable iff (rst)
        (din > level) |=> (level == $past(din)));
      // R4: relaxation moves down, never past the midpoint
      a_r4_pos_relax: assert property (@(posedge clk) disable iff (rst)
        (stb && !(din > level)) |=> ((level <= $past(level)) && (level >= $past(mid))));
    end else begin : g_neg
      always_comb begin
        jump = din < level;
        gap  = mid - level_x;
        nxt  = level_x + step;
      end
      // R3: an excursion below the level is captured at once
      a_r3_neg_jump: assert property (@(posedge clk) disable iff (rst)
        (din < level) |=> (level == $past(din)));
      // R4: relaxation moves up, never past the midpoint
      a_r4_neg_relax: assert property (@(posedge clk) disable iff (rst)
        (stb && !(din < level)) |=> ((level >= $past(level)) && (level <= $past(mid))));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= '0;
    end else if (jump) begin
      level <= din;
    end else if (stb) begin
      level <= nxt[W-1:0];
    end
  end

  // R4: the relaxed value always fits the level register
  a_r4_fits: assert property (@(posedge clk) disable iff (rst)
    (stb && !jump) |-> (nxt[W] == nxt[W-1]));
  // R4: without strobe or jump the level holds
  a_r4_idle: assert property (@(posedge clk) disable iff (rst)
    (!stb && !jump) |=> $stable(level));
endmodule

// File: rtl/slicer_thresh.sv
module slicer_thresh #(
  parameter int W        = 8,
  parameter int SH_NARROW = 2,
  parameter int SH_WIDE   = 3
) (
  input  logic signed [W-1:0] pos,
  input  logic signed [W-1:0] neg,
  input  logic                prev_bit,
  input  logic                wide,
  output logic signed [W:0]   mid,
  output logic signed [W+1:0] thr
);
  localparam int XW = W + 2;

  logic signed [W:0]    sum;
  logic signed [W:0]    span;
  logic signed [W:0]    k;
  logic signed [XW-1:0] mid_x;
  logic signed [XW-1:0] k_x;

  always_comb begin
    sum   = {pos[W-1], pos} + {neg[W-1], neg};
    span  = {pos[W-1], pos} - {neg[W-1], neg};
    mid   = sum >>> 1;
    k     = wide ? (span >>> SH_WIDE) : (span >>> SH_NARROW);
    mid_x = {mid[W], mid};
    k_x   = {k[W], k};
    thr   = prev_bit ? (mid_x + k_x) : (mid_x - k_x);
  end
endmodule

// File: rtl/slicer_decide.sv
module slicer_decide #(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] din,
  input  logic signed [W+1:0] thr,
  input  logic                stb,
  output logic                bit_o,
  output logic                vld_o
);
  logic signed [W+1:0] din_x;
  logic                above;

  assign din_x = {{2{din[W-1]}}, din};
  assign above = din_x > thr;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_o <= 1'b0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= stb;
      if (stb) begin
        bit_o <= above;
      end
    end
  end

  // R7: one valid pulse per strobe
  a_r7_pulse: assert property (@(posedge clk) disable iff (rst)
    stb |=> vld_o);
  // R7: no strobe, no pulse, bit held
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !stb |=> (!vld_o && $stable(bit_o)));
  // R6: a sample at or below the threshold never gives 1
  a_r6_strict: assert property (@(posedge clk) disable iff (rst)
    (stb && (din_x <= thr)) |=> !bit_o);
endmodule

// File: rtl/isi_slicer.sv
module isi_slicer #(
  parameter int W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic signed [W-1:0] sample_i,
  input  logic                mid_stb_i,
  input  logic                acquire_i,
  input  logic                bt_sel_i,
  output logic                bit_o,
  output logic                bit_vld_o
);
  import slicer_pkg::*;

  logic signed [W-1:0] pos_lvl;
  logic signed [W-1:0] neg_lvl;
  logic signed [W:0]   mid;
  logic signed [W+1:0] thr;
  logic                fast;
  logic                wide;

  assign fast = (track_e'(acquire_i) == TRACK_FAST);
  assign wide = (filt_e'(bt_sel_i) == FILT_WIDE);

  slicer_level #(
    .W(W), .IS_POS(1'b1), .SH_FAST(RELAX_FAST), .SH_SLOW(RELAX_SLOW)
  ) u_pos (
    .clk(clk), .rst(rst), .din(sample_i), .mid(mid),
    .stb(mid_stb_i), .fast(fast), .level(pos_lvl)
  );

  slicer_level #(
    .W(W), .IS_POS(1'b0), .SH_FAST(RELAX_FAST), .SH_SLOW(RELAX_SLOW)
  ) u_neg (
    .clk(clk), .rst(rst), .din(sample_i), .mid(mid),
    .stb(mid_stb_i), .fast(fast), .level(neg_lvl)
  );

  // R8: the previous decision is the registered output bit
  slicer_thresh #(
    .W(W), .SH_NARROW(SPAN_NARROW), .SH_WIDE(SPAN_WIDE)
  ) u_thr (
    .pos(pos_lvl), .neg(neg_lvl), .prev_bit(bit_o), .wide(wide),
    .mid(mid), .thr(thr)
  );

  slicer_decide #(.W(W)) u_dec (
    .clk(clk), .rst(rst), .din(sample_i), .thr(thr),
    .stb(mid_stb_i), .bit_o(bit_o), .vld_o(bit_vld_o)
  );

  // R1: reset clears the outputs on the next edge
  a_r1_reset: assert property (@(posedge clk)
    rst |=> (!bit_o && !bit_vld_o));
  // R4: the two levels never cross
  a_r4_order: assert property (@(posedge clk) disable iff (rst)
    pos_lvl >= neg_lvl);
endmodule

// File: tb/isi_slicer_tb_top.sv
module isi_slicer_tb_top;
  localparam int CLK_P = 10;
  localparam int NV    = 20;
  // {strobe, acquire, bt_sel, sample[7:0]}
  localparam logic [10:0] VEC [0:NV-1] = '{
    {3'b110, 8'sd100}, {3'b010, -8'sd100}, {3'b110, 8'sd10},
    {3'b110, -8'sd60}, {3'b100, -8'sd50}, {3'b101, 8'sd20},
    {3'b001, 8'sd127}, {3'b101, -8'sd128}, {3'b111, 8'sd0},
    {3'b110, 8'sd30}, {3'b010, 8'sd5}, {3'b100, -8'sd1},
    {3'b100, 8'sd1}, {3'b110, 8'sd90}, {3'b111, -8'sd90},
    {3'b000, 8'sd3}, {3'b101, 8'sd40}, {3'b110, -8'sd40},
    {3'b100, 8'sd126}, {3'b101, -8'sd127}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic signed [7:0] sample_i = '0;
  logic mid_stb_i = 1'b0;
  logic acquire_i = 1'b0;
  logic bt_sel_i  = 1'b0;
  logic bit_o, bit_vld_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int mp = 0, mn = 0;
  bit mprev = 1'b0;

  isi_slicer #(.W(8)) dut_i (
    .clk(clk), .rst(rst), .sample_i(sample_i), .mid_stb_i(mid_stb_i),
    .acquire_i(acquire_i), .bt_sel_i(bt_sel_i),
    .bit_o(bit_o), .bit_vld_o(bit_vld_o)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; mid_stb_i = 1'b0; sample_i = '0;
    @(posedge clk); @(posedge clk);
    #1;
    check("R1 bit", int'(bit_o), 0);
    check("R1 vld", int'(bit_vld_o), 0);
    @(negedge clk);
    rst = 1'b0;
    mp = 0; mn = 0; mprev = 1'b0;
  endtask

  // One clock: model from the requirements, then compare the ports.
  task automatic step(input string tag, input int s, input bit stb,
                      input bit acq, input bit bt);
    int mid, k, thr, sh;
    bit e;
    @(negedge clk);
    sample_i = 8'(s); mid_stb_i = stb; acquire_i = acq; bt_sel_i = bt;
    mid = (mp + mn) >>> 1;                 // R4/R5 midpoint
    k   = (mp - mn) >>> (bt ? 3 : 2);      // R5 span fraction
    thr = mprev ? mid + k : mid - k;       // R5/R8
    e   = (s > thr);                       // R6 strict compare
    sh  = acq ? 4 : 8;                     // R9
    @(posedge clk);
    #1;
    if (stb) begin
      check({tag, " R7 vld"}, int'(bit_vld_o), 1);
      check({tag, " R6 bit"}, int'(bit_o), int'(e));
      mprev = e;
    end else begin
      check({tag, " R7 vld"}, int'(bit_vld_o), 0);
      check({tag, " R7 hold"}, int'(bit_o), int'(mprev));
    end
    if (s > mp) mp = s;                    // R2
    else if (stb) mp = mp - ((mp - mid) >>> sh);
    if (s < mn) mn = s;                    // R3
    else if (stb) mn = mn + ((mid - mn) >>> sh);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R6: zero levels, sample equal to threshold gives 0
    step("R6 equal", 0, 1'b1, 1'b1, 1'b0);
    // R2/R6: jump and decision in the same cycle; old threshold decides
    step("R2 collide", 1, 1'b1, 1'b1, 1'b0);
    step("R3 collide", -1, 1'b1, 1'b1, 1'b0);

    do_reset();
    for (int i = 0; i < NV; i++) begin
      step("R2/R3/R4 table", int'($signed(VEC[i][7:0])),
           VEC[i][10], VEC[i][9], VEC[i][8]);
    end

    // R5: span 200, narrow filter, prev 0 -> threshold -50
    do_reset();
    step("R2 set", 100, 1'b0, 1'b0, 1'b0);
    step("R3 set", -100, 1'b0, 1'b0, 1'b0);
    step("R5 narrow edge", -50, 1'b1, 1'b0, 1'b0);
    step("R5 narrow above", -49, 1'b1, 1'b0, 1'b0);
    step("R5 prev1", 23, 1'b1, 1'b0, 1'b1);
    step("R5 wide", 26, 1'b1, 1'b0, 1'b1);

    // R9: acquire vs hold relaxation over many strobes
    for (int i = 0; i < 40; i++) step("R9 fast", (i % 2) ? 3 : -3, 1'b1, 1'b1, 1'b0);
    do_reset();
    step("R2 set", 120, 1'b0, 1'b0, 1'b0);
    step("R3 set", -120, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 40; i++) step("R9 slow", (i % 2) ? 3 : -3, 1'b1, 1'b0, 1'b1);

    // R4/R5/R8: pseudo-random burst with an offset
    for (int i = 0; i < 600; i++) begin
      int v;
      v = int'($urandom_range(0, 160)) - 50;
      step("R4/R5/R8 burst", v, ($urandom_range(0, 3) == 0), (i < 200),
           (i % 97) > 48);
    end

    // R1: reset in mid-run
    do_reset();
    step("R1 after", 5, 1'b1, 1'b0, 1'b0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule